// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block drives a port of `PINS` pads from a simple register bus. For each pin, software chooses the direction, the value to drive, push-pull or open-drain output, and a pull-up request that goes straight to the pad. Pad inputs pass through a two-stage synchronizer. Software reads that synchronized level, which is separate from the stored output value. A peripheral can take a pin over. While the peripheral owns the pin, its data and drive-enable replace the software settings, and the open-drain stage still applies after the selection.

Each control register has four word addresses. One replaces the register, and the other three clear, set or invert only the bits written as 1, all in a single write. A change-notification unit watches selected synchronized inputs. It compares each input with its value one cycle earlier and records any edge in a sticky, write-one-to-clear status register. A single interrupt line reports that status while the global enable is on.

The block has no sequencing: every output is a register or a combinational function of registers and inputs. Its only named operating conditions are "in reset" and "running".

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0) and the direction register reads all ones. Latch, open-drain, pull-up, pin-enable, global-enable and status read 0, and `irq` is 0.
- R2: The word address splits into two fields. `bus_addr[4:2]` selects the register: 0 pin level, 1 latch, 2 direction (1 = input), 3 open-drain, 4 pull-up, 5 notify pin-enable, 6 notify global enable (bit 0), 7 notify status. `bus_addr[1:0]` selects the operation: 0 replace, 1 clear, 2 set, 3 invert. A replace write loads the written value.
- R3: A clear, set or invert write changes only the bits written as 1, in one write.
- R4: Reads at operation codes 1 to 3 return 0. Writes to the pin-level register change nothing.
- R5: The pin-level read shows `pad_in` two clock edges after the pad changes (still old after one edge). The latch read keeps returning the stored value.
- R6: On a pin not owned by a peripheral, the drive-enable is the inverse of the direction bit and the driven value is the latch bit.
- R7: On an open-drain pin, `pad_out` is 0 and `pad_oe` is 1 only while the selected data is 0.
- R8: While `per_en[i]` is 1, pin i takes its data from `per_out[i]` and its drive-enable from `per_oe[i]`.
- R9: A rising or falling change on a synchronized input whose pin-enable bit is 1 sets that status bit, visible three edges after the pad change. The bit stays set. Changes on pins that are not enabled set nothing.
- R10: Writing 1s to the status register at operation 0 or 1 clears those bits. A new change in the same cycle wins over the clear. Set and invert writes to status are ignored.
- R11: `irq` is the OR of all status bits ANDed with the global enable.
- R12: `pad_pu` equals the pull-up register.
- R13: The pin-level read follows the pad even on pins driven as outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address: register select and operation |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational from `bus_addr` |
| pad_in | input | PINS | Pad input levels |
| pad_out | output | PINS | Pad output data |
| pad_oe | output | PINS | Pad drive-enable |
| pad_pu | output | PINS | Pull-up request to the pad |
| per_en | input | PINS | Peripheral takes over the pin |
| per_out | input | PINS | Peripheral output data |
| per_oe | input | PINS | Peripheral drive-enable |
| irq | output | 1 | Change-notification interrupt |

## Verification
The latch is driven through a chain of replace, set, clear and invert writes. Each value that follows can only come from the right bit-level operation, and reads at the alias addresses and writes to the pin-level register show that they have no effect. The pad outputs are then checked under four ownership patterns: software push-pull, software open-drain with the latch high and with it low, and a peripheral taking over both a push-pull pin and an open-drain pin. These patterns separate the mux from the open-drain stage. Change notification is tried with a rising edge and a falling edge on enabled pins and an edge on a pin that is not enabled. The status is then cleared bit by bit and the global enable is switched off, which separates the sticky status from the interrupt gate.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        OP_BASE = 2'd0,
        OP_CLR  = 2'd1,
        OP_SET  = 2'd2,
        OP_INV  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RG_PORT   = 3'd0,
        RG_LAT    = 3'd1,
        RG_DIR    = 3'd2,
        RG_ODC    = 3'd3,
        RG_PUE    = 3'd4,
        RG_CNEN   = 3'd5,
        RG_CNCTL  = 3'd6,
        RG_CNSTAT = 3'd7
    } reg_e;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  op_e          op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (op)
            OP_BASE: q_nxt = wdata;
            OP_CLR:  q_nxt = q & ~wdata;
            OP_SET:  q_nxt = q | wdata;
            OP_INV:  q_nxt = q ^ wdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (wr_en)
            q <= q_nxt;
    end

    // R3: alias operations touch only the bits written as 1
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR) |=> ((q & $past(wdata)) == '0));
    assert_keep_unwritten_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op != OP_BASE) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    // R2: replace write loads the data, idle cycles hold
    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_BASE) |=> (q == $past(wdata)));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= async_in[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/gpio_cn.sv
module gpio_cn #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] pin_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    logic [W-1:0] prev_level;
    logic [W-1:0] edge_hit;

    assign edge_hit = (level ^ prev_level) & pin_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_level <= '0;
            status     <= '0;
        end else begin
            prev_level <= level;
            status     <= (status & ~clr_mask) | edge_hit;
        end
    end

    // R9: bits stay set unless a clear is requested
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status & $past(status)) == $past(status)));
    // R10: a new change wins over a same-cycle clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pu,
    input  logic [PINS-1:0]   per_en,
    input  logic [PINS-1:0]   per_out,
    input  logic [PINS-1:0]   per_oe,
    output logic              irq
);

    localparam int NCTL = 5;

    reg_e sel;
    op_e  op;
    assign sel = reg_e'(bus_addr[ADDR_W-1:2]);
    assign op  = op_e'(bus_addr[1:0]);

    // control registers: latch, direction, open-drain, pull-up, notify enable
    logic [PINS-1:0] ctl_q [NCTL];

    for (genvar k = 0; k < NCTL; k++) begin : g_ctl
        localparam logic [PINS-1:0] RV = (k == 1) ? {PINS{1'b1}} : {PINS{1'b0}};
        gpio_alias_reg #(.W(PINS), .RST_VAL(RV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wen && (sel == reg_e'(3'(k + 1)))),
            .op    (op),
            .wdata (bus_wdata),
            .q     (ctl_q[k])
        );
    end

    logic [PINS-1:0] lat_q, dir_q, odc_q, pue_q, cnen_q;
    assign lat_q  = ctl_q[0];
    assign dir_q  = ctl_q[1];
    assign odc_q  = ctl_q[2];
    assign pue_q  = ctl_q[3];
    assign cnen_q = ctl_q[4];

    logic cn_on;
    gpio_alias_reg #(.W(1), .RST_VAL(1'b0)) u_cnctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wen && (sel == RG_CNCTL)),
        .op    (op),
        .wdata (bus_wdata[0]),
        .q     (cn_on)
    );

    logic [PINS-1:0] pin_level;
    gpio_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_level)
    );

    logic [PINS-1:0] stat_clr;
    logic [PINS-1:0] cn_status;
    assign stat_clr = (bus_wen && sel == RG_CNSTAT && (op == OP_BASE || op == OP_CLR))
                      ? bus_wdata : '0;

    gpio_cn #(.W(PINS)) u_cn (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_level),
        .pin_en   (cnen_q),
        .clr_mask (stat_clr),
        .status   (cn_status)
    );

    assign irq = cn_on && (|cn_status);

    // read path: alias addresses read as zero
    always_comb begin
        bus_rdata = '0;
        if (op == OP_BASE) begin
            unique case (sel)
                RG_PORT:   bus_rdata = pin_level;
                RG_LAT:    bus_rdata = lat_q;
                RG_DIR:    bus_rdata = dir_q;
                RG_ODC:    bus_rdata = odc_q;
                RG_PUE:    bus_rdata = pue_q;
                RG_CNEN:   bus_rdata = cnen_q;
                RG_CNCTL:  bus_rdata = {{(PINS-1){1'b0}}, cn_on};
                RG_CNSTAT: bus_rdata = cn_status;
            endcase
        end
    end

    // output multiplexer then open-drain stage, per pin
    logic [PINS-1:0] drv_data, drv_oe;
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        always_comb begin
            drv_data[p] = per_en[p] ? per_out[p] : lat_q[p];
            drv_oe[p]   = per_en[p] ? per_oe[p]  : ~dir_q[p];
            if (odc_q[p]) begin
                pad_out[p] = 1'b0;
                pad_oe[p]  = drv_oe[p] & ~drv_data[p];
            end else begin
                pad_out[p] = drv_data[p];
                pad_oe[p]  = drv_oe[p];
            end
        end
    end

    assign pad_pu = pue_q;

    // R7: an open-drain pin never drives high
    assert_od_low_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & odc_q) == '0));
    // R8: an owned push-pull pin follows the peripheral
    assert_per_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_en & ~odc_q & ((pad_out ^ per_out) | (pad_oe ^ per_oe))) == '0));
    // R11: no interrupt while notification is globally off
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cn_on);
    // R4: writes to the pin-level register leave the latch alone
    assert_port_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && sel == RG_PORT) |=> $stable(lat_q));

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    localparam int PINS = 8;
    // address fields: {register[2:0], op[1:0]}
    localparam logic [4:0] A_PORT   = 5'd0;
    localparam logic [4:0] A_LAT    = 5'd4;
    localparam logic [4:0] A_LATSET = 5'd6;
    localparam logic [4:0] A_DIR    = 5'd8;
    localparam logic [4:0] A_ODC    = 5'd12;
    localparam logic [4:0] A_PUE    = 5'd16;
    localparam logic [4:0] A_CNEN   = 5'd20;
    localparam logic [4:0] A_CNCTL  = 5'd24;
    localparam logic [4:0] A_CNCCLR = 5'd25;
    localparam logic [4:0] A_STAT   = 5'd28;
    localparam logic [4:0] A_STATSET= 5'd30;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic            bus_wen = 1'b0;
    logic [PINS-1:0] bus_wdata = '0;
    logic [PINS-1:0] bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out, pad_oe, pad_pu;
    logic [PINS-1:0] per_en = '0, per_out = '0, per_oe = '0;
    logic            irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.PINS(PINS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .per_en(per_en), .per_out(per_out), .per_oe(per_oe), .irq(irq)
    );

    // register-walk table: {write addr, write data, read addr, expected}
    // covers R2 replace, R3 clear/set/invert, R4 alias read and port write
    localparam int NV = 11;
    localparam logic [25:0] VEC [NV] = '{
        {5'd4,  8'hA5, 5'd4,  8'hA5},
        {5'd6,  8'h0F, 5'd4,  8'hAF},
        {5'd5,  8'h81, 5'd4,  8'h2E},
        {5'd7,  8'hFF, 5'd4,  8'hD1},
        {5'd6,  8'h00, 5'd6,  8'h00},
        {5'd8,  8'h00, 5'd8,  8'h00},
        {5'd11, 8'hF0, 5'd8,  8'hF0},
        {5'd14, 8'h3C, 5'd12, 8'h3C},
        {5'd14, 8'h00, 5'd14, 8'h00},
        {5'd0,  8'hFF, 5'd4,  8'hD1},
        {5'd16, 8'h5A, 5'd16, 8'h5A}
    };

    task automatic check(input string tag, input logic [PINS-1:0] act,
                         input logic [PINS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [PINS-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [PINS-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check_defaults(input string tag);
        logic [PINS-1:0] v;
        rd(A_DIR, v);   check(tag, v, 8'hFF);
        rd(A_LAT, v);   check(tag, v, 8'h00);
        rd(A_ODC, v);   check(tag, v, 8'h00);
        rd(A_PUE, v);   check(tag, v, 8'h00);
        rd(A_CNEN, v);  check(tag, v, 8'h00);
        rd(A_CNCTL, v); check(tag, v, 8'h00);
        rd(A_STAT, v);  check(tag, v, 8'h00);
        check(tag, pad_oe, 8'h00);
        check(tag, {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [PINS-1:0] v;
        steps(3);
        rst_n = 1'b1;
        steps(1);
        check_defaults("R1 reset state");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][25:21], VEC[i][20:13]);
            rd(VEC[i][12:8], v);
            check($sformatf("R2/R3/R4 table row %0d", i), v, VEC[i][7:0]);
        end

        // dir=F0 lat=D1 odc=3C: pins 0-3 driven, pins 2-5 open-drain
        check("R6 push-pull data", pad_out, 8'hC1);
        check("R6/R7 drive enable", pad_oe, 8'h0F);
        wr(A_LATSET, 8'h08);   // pin3 open-drain high -> released
        check("R7 open-drain release", pad_oe, 8'h07);
        check("R7 open-drain data low", pad_out, 8'hC1);

        per_en = 8'h03; per_out = 8'h02; per_oe = 8'h01;
        #1;
        check("R8 peripheral data", pad_out, 8'hC2);
        check("R8 peripheral enable", pad_oe, 8'h05);
        per_en = 8'h04; per_out = 8'h04; per_oe = 8'h04;
        #1;
        check("R7/R8 peripheral on open-drain", pad_oe, 8'h03);
        check("R7/R8 open-drain data", pad_out, 8'hC1);
        per_en = '0; per_out = '0; per_oe = '0;
        check("R12 pull-up pass", pad_pu, 8'h5A);

        // R5 / R13 two-stage input, pins 1 and 2 are outputs driving low
        @(negedge clk);
        pad_in = 8'h96;
        steps(1);
        rd(A_PORT, v); check("R5 one edge still old", v, 8'h00);
        steps(1);
        rd(A_PORT, v); check("R5/R13 port after two edges", v, 8'h96);
        rd(A_LAT, v);  check("R5 latch distinct", v, 8'hD9);
        steps(3);

        // change notification on pins 4 and 5
        wr(A_CNEN, 8'h30);
        wr(A_CNCTL, 8'h01);
        rd(A_STAT, v); check("R9 no stale status", v, 8'h00);
        pad_in = 8'hB6;            // pin5 rises
        steps(3);
        rd(A_STAT, v); check("R9 rising edge", v, 8'h20);
        check("R11 irq raised", {7'd0, irq}, 8'h01);
        pad_in = 8'hF6;            // pin6 rises, not enabled
        steps(3);
        rd(A_STAT, v); check("R9 disabled pin ignored", v, 8'h20);
        pad_in = 8'hE6;            // pin4 falls
        steps(3);
        rd(A_STAT, v); check("R9 falling edge", v, 8'h30);
        wr(A_STAT, 8'h10);
        rd(A_STAT, v); check("R10 write-one clear", v, 8'h20);
        wr(A_STATSET, 8'h10);
        rd(A_STAT, v); check("R10 set alias ignored", v, 8'h20);
        check("R11 irq still up", {7'd0, irq}, 8'h01);
        wr(A_CNCCLR, 8'h01);
        check("R11 irq gated off", {7'd0, irq}, 8'h00);
        rd(A_STAT, v); check("R11 status kept", v, 8'h20);
        wr(A_STAT, 8'h20);
        rd(A_STAT, v); check("R10 cleared all", v, 8'h00);

        // reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        steps(2);
        rst_n = 1'b1;
        steps(1);
        check_defaults("R1 second reset");

        summary();
    end

endmodule